// File: doc/BRIEF.md
# Entropy Seed CSR Access Unit

This unit serves a processor's entropy-seed control/status register at CSR address 0x015. A CSR request carries the address, the current privilege level, a virtualization flag and a flag that tells a true read-write instruction apart from a read-only form. The unit applies the access rules using two enable bits taken from the machine security configuration register. For each request it returns either a seed word or an exception code.

A 16-bit sample buffer is filled from an external entropy-sample port with a valid/ready handshake. A permitted read formats the buffer into a word whose two top bits give the source state. A read that returns a sample empties the buffer at once, so a sample can never be handed out twice. A sticky failure input drives every later permitted read to the dead state, so software stops polling.

Top module: `seed_csr_unit`

## Requirements
- R1: A request with `req_valid` high and `req_addr` equal to 0x015 is answered with `rsp_valid` high exactly one clock later. A request to any other address gives no response.
- R2: A read-only form (`req_rw` = 0) at any privilege gets exception code 01 (illegal instruction).
- R3: A read-write access at machine privilege (`req_priv` = 2'b11) is always permitted (exception code 00).
- R4: A read-write access below machine privilege with `req_virt` = 1 gets code 10 (virtual-instruction fault) when `cfg_sseed` = 1. It gets code 01 when `cfg_sseed` = 0.
- R5: A non-virtual supervisor access (`req_priv` = 2'b01) is permitted only when `cfg_sseed` = 1. Otherwise it gets code 01.
- R6: A non-virtual user access (`req_priv` = 2'b00) is permitted only when `cfg_useed` = 1. Otherwise it gets code 01. The reserved level 2'b10 always gets code 01.
- R7: With a sample buffered and no failure or self-test, a permitted read returns status 2'b10 in bits 31:30, the sample in bits 15:0, and zero in bits 29:16.
- R8: With the buffer empty, a permitted read returns status 2'b01 and zero in bits 29:0.
- R9: A read that returns status 2'b10 empties the buffer. `ent_ready` is high in the response cycle, and the next read returns status 2'b01 unless a new sample has arrived.
- R10: A denied access returns zero data and leaves a buffered sample in place for a later permitted read.
- R11: A single-cycle pulse on `ent_fail` is held until reset. Every later permitted read returns status 2'b11 with bits 29:0 zero, and this status takes priority over all others.
- R12: While `ent_bist` is high and no failure is held, a permitted read returns status 2'b00 with bits 29:0 zero and does not consume the buffer.
- R13: `ent_ready` is high out of reset and while the buffer is empty. A sample is taken only when `ent_valid` and `ent_ready` are both high. A sample offered while the buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CSR request strobe |
| req_addr | input | 12 | CSR address of the request |
| req_priv | input | 2 | Privilege level: 00 user, 01 supervisor, 11 machine |
| req_virt | input | 1 | Request issued from a virtualized mode |
| req_rw | input | 1 | 1 for a true read-write form, 0 for a read-only form |
| cfg_useed | input | 1 | User-level seed access enable |
| cfg_sseed | input | 1 | Supervisor-level seed access enable |
| ent_valid | input | 1 | Entropy sample offered |
| ent_data | input | 16 | Entropy sample value |
| ent_ready | output | 1 | Sample buffer empty and able to accept a sample |
| ent_fail | input | 1 | Unrecoverable failure of the entropy source |
| ent_bist | input | 1 | Entropy source running its self-test |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Seed word, zero when denied |
| rsp_exc | output | 2 | 00 none, 01 illegal instruction, 10 virtual-instruction fault |

## Verification
The hardest case to reach from the ports is a read that arrives while a sample is held and the access is denied or the source is in self-test. Consuming the sample at the wrong moment is visible only in a later read. The stimulus loads one known sample and then runs a series of denied accesses and a self-test read against it, covering every privilege, virtualization and enable combination. It then reads with permission and expects that same sample, so any stray consumption shows up as a wait status. The sticky failure is tested the same way: a one-cycle pulse is followed by reads several cycles later.

// File: rtl/seed_pkg.sv
package seed_pkg;
  typedef enum logic [1:0] {
    ST_BIST = 2'b00,
    ST_WAIT = 2'b01,
    ST_ES16 = 2'b10,
    ST_DEAD = 2'b11
  } seed_state_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'b00,
    EXC_ILLEGAL = 2'b01,
    EXC_VIRT    = 2'b10
  } seed_exc_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/seed_access_check.sv
module seed_access_check
  import seed_pkg::*;
(
  input  logic      [1:0] priv,
  input  logic            virt,
  input  logic            rw_form,
  input  logic            en_user,
  input  logic            en_super,
  output seed_exc_e       exc
);
  // Ordering matters: the read-only form traps first, then machine mode,
  // then virtualized modes, then the per-level enables.
  always_comb begin
    exc = EXC_ILLEGAL;
    if (!rw_form) begin
      exc = EXC_ILLEGAL;
    end else if (priv == PRIV_M) begin
      exc = EXC_NONE;
    end else if (virt) begin
      exc = en_super ? EXC_VIRT : EXC_ILLEGAL;
    end else if (priv == PRIV_S) begin
      exc = en_super ? EXC_NONE : EXC_ILLEGAL;
    end else if (priv == PRIV_U) begin
      exc = en_user ? EXC_NONE : EXC_ILLEGAL;
    end
  end
endmodule

// File: rtl/seed_entropy_buf.sv
module seed_entropy_buf #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                fail_evt,
  input  logic                take,
  output logic                full,
  output logic [SAMPLE_W-1:0] data,
  output logic                dead
);
  logic                full_q, full_d;
  logic                dead_q, dead_d;
  logic [SAMPLE_W-1:0] data_q;
  logic                load;

  always_comb begin
    load   = smp_valid && !full_q;
    full_d = full_q;
    if (take)  full_d = 1'b0;
    if (load)  full_d = 1'b1;
    dead_d = dead_q || fail_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      full_q <= full_d;
      dead_q <= dead_d;
    end
  end

  // Data register carries an explicit enable; contents do not matter when empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= smp_data;
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign dead = dead_q;
endmodule

// File: rtl/seed_word_fmt.sv
module seed_word_fmt
  import seed_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic                full,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                dead,
  input  logic                bist,
  output seed_state_e         state,
  output logic [XLEN-1:0]     word
);
  localparam int PAD_W = XLEN - 2 - SAMPLE_W;

  always_comb begin
    if (dead)       state = ST_DEAD;
    else if (bist)  state = ST_BIST;
    else if (full)  state = ST_ES16;
    else            state = ST_WAIT;
  end

  always_comb begin
    word = {state, {PAD_W{1'b0}}, {SAMPLE_W{1'b0}}};
    if (state == ST_ES16) begin
      word[SAMPLE_W-1:0] = sample;
    end
  end
endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit
  import seed_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          XLEN      = 32,
  parameter int          SAMPLE_W  = 16,
  parameter logic [11:0] SEED_ADDR = 12'h015
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_priv,
  input  logic                req_virt,
  input  logic                req_rw,
  input  logic                cfg_useed,
  input  logic                cfg_sseed,
  input  logic                ent_valid,
  input  logic [SAMPLE_W-1:0] ent_data,
  output logic                ent_ready,
  input  logic                ent_fail,
  input  logic                ent_bist,
  output logic                rsp_valid,
  output logic [XLEN-1:0]     rsp_data,
  output logic [1:0]          rsp_exc
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SEED_ADDR);

  logic                hit;
  logic                grant;
  logic                take;
  seed_exc_e           exc;
  logic                buf_full;
  logic                buf_dead;
  logic [SAMPLE_W-1:0] buf_data;
  seed_state_e         state;
  logic [XLEN-1:0]     word;

  logic                vld_q, vld_d;
  logic [XLEN-1:0]     dat_q, dat_d;
  logic [1:0]          exc_q, exc_d;

  seed_access_check u_check (
    .priv     (req_priv),
    .virt     (req_virt),
    .rw_form  (req_rw),
    .en_user  (cfg_useed),
    .en_super (cfg_sseed),
    .exc      (exc)
  );

  seed_entropy_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (ent_valid),
    .smp_data  (ent_data),
    .fail_evt  (ent_fail),
    .take      (take),
    .full      (buf_full),
    .data      (buf_data),
    .dead      (buf_dead)
  );

  seed_word_fmt #(.XLEN(XLEN), .SAMPLE_W(SAMPLE_W)) u_fmt (
    .full   (buf_full),
    .sample (buf_data),
    .dead   (buf_dead),
    .bist   (ent_bist),
    .state  (state),
    .word   (word)
  );

  always_comb begin
    hit   = req_valid && (req_addr == MATCH);
    grant = hit && (exc == EXC_NONE);
    take  = grant && (state == ST_ES16);
    vld_d = hit;
    exc_d = hit ? exc : EXC_NONE;
    dat_d = grant ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      exc_q <= EXC_NONE;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      exc_q <= exc_d;
    end
  end

  assign ent_ready = !buf_full;
  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;
  assign rsp_exc   = exc_q;
endmodule

// File: rtl/seed_csr_chk.sv
module seed_csr_chk #(
  parameter int          ADDR_W    = 12,
  parameter int          XLEN      = 32,
  parameter logic [11:0] SEED_ADDR = 12'h015
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_priv,
  input logic              req_virt,
  input logic              req_rw,
  input logic              cfg_sseed,
  input logic              ent_ready,
  input logic              rsp_valid,
  input logic [XLEN-1:0]   rsp_data,
  input logic [1:0]        rsp_exc
);
  logic hit;
  assign hit = req_valid && (req_addr == ADDR_W'(SEED_ADDR));

  p_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rsp_valid);
  p_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !rsp_valid);
  p_ro_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_rw) |=> (rsp_exc == 2'b01));
  p_machine_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_rw && req_priv == 2'b11) |=> (rsp_exc == 2'b00));
  p_virt_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_rw && req_virt && req_priv != 2'b11)
      |=> (rsp_exc == ($past(cfg_sseed) ? 2'b10 : 2'b01)));
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[XLEN-1:XLEN-2] == 2'b10) |-> (rsp_data[XLEN-3:16] == '0));
  p_wait_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[XLEN-1:XLEN-2] == 2'b01) |-> (rsp_data[XLEN-3:0] == '0));
  p_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'b00 && rsp_data[XLEN-1:XLEN-2] == 2'b10) |-> ent_ready);
  p_denied_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc != 2'b00) |-> (rsp_data == '0));
  p_dead_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[XLEN-1:XLEN-2] == 2'b11) |-> (rsp_data[XLEN-3:0] == '0));
  p_exc_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc != 2'b11);
endmodule

bind seed_csr_unit seed_csr_chk #(
  .ADDR_W(ADDR_W), .XLEN(XLEN), .SEED_ADDR(SEED_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_priv  (req_priv),
  .req_virt  (req_virt),
  .req_rw    (req_rw),
  .cfg_sseed (cfg_sseed),
  .ent_ready (ent_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_exc   (rsp_exc)
);

// File: tb/sim_seed_csr_unit.sv
module sim_seed_csr_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [11:0] req_addr;
  logic [1:0]  req_priv;
  logic        req_virt;
  logic        req_rw;
  logic        cfg_useed;
  logic        cfg_sseed;
  logic        ent_valid;
  logic [15:0] ent_data;
  logic        ent_ready;
  logic        ent_fail;
  logic        ent_bist;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_exc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] q_data[$];
  logic [1:0]  q_exc[$];
  string       q_tag[$];

  seed_csr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_virt(req_virt), .req_rw(req_rw),
    .cfg_useed(cfg_useed), .cfg_sseed(cfg_sseed), .ent_valid(ent_valid),
    .ent_data(ent_data), .ent_ready(ent_ready), .ent_fail(ent_fail),
    .ent_bist(ent_bist), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_exc(rsp_exc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop the oldest expectation whenever a response appears.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R1 unexpected response: actual %h expected none", rsp_data);
      end else begin
        automatic string t = q_tag.pop_front();
        check({t, " data"}, rsp_data, q_data.pop_front());
        check({t, " exc"}, {30'd0, rsp_exc}, {30'd0, q_exc.pop_front()});
      end
    end
  end

  // Driver: issue one request and queue the expected answer.
  task automatic access(input logic [11:0] addr, input logic [1:0] priv, input logic virt,
                        input logic rw, input logic [31:0] exp_d, input logic [1:0] exp_e,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_priv = priv; req_virt = virt; req_rw = rw;
    if (addr == 12'h015) begin
      q_data.push_back(exp_d); q_exc.push_back(exp_e); q_tag.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed(input logic [15:0] s);
    @(negedge clk);
    ent_valid = 1'b1; ent_data = s;
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_priv = 0; req_virt = 0; req_rw = 0;
    cfg_useed = 0; cfg_sseed = 0; ent_valid = 0; ent_data = 0; ent_fail = 0; ent_bist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R13 reset ent_ready", {31'd0, ent_ready}, 32'd1);

    access(12'h015, 2'b11, 0, 1, 32'h4000_0000, 2'b00, "R8 R3 empty machine read");

    feed(16'hA5C3);
    check("R13 ready after load", {31'd0, ent_ready}, 32'd0);
    feed(16'h1111);  // dropped, buffer full (R13)

    access(12'h015, 2'b00, 0, 1, 32'h0, 2'b01, "R6 user disabled");
    cfg_useed = 1;
    access(12'h015, 2'b00, 0, 0, 32'h0, 2'b01, "R2 user read-only");
    access(12'h015, 2'b11, 0, 0, 32'h0, 2'b01, "R2 machine read-only");
    access(12'h015, 2'b01, 0, 1, 32'h0, 2'b01, "R5 super disabled");
    access(12'h015, 2'b10, 0, 1, 32'h0, 2'b01, "R6 reserved level");
    access(12'h015, 2'b00, 1, 1, 32'h0, 2'b01, "R4 virt user sseed=0");
    cfg_sseed = 1;
    access(12'h015, 2'b01, 1, 1, 32'h0, 2'b10, "R4 virt super sseed=1");
    access(12'h015, 2'b00, 1, 1, 32'h0, 2'b10, "R4 virt user sseed=1");
    access(12'h016, 2'b11, 0, 1, 32'h0, 2'b00, "R1 other address");
    check("R1 no response other addr", {31'd0, rsp_valid}, 32'd0);
    check("R10 sample kept", {31'd0, ent_ready}, 32'd0);

    access(12'h015, 2'b00, 0, 1, 32'h8000_A5C3, 2'b00, "R7 R10 R13 user read sample");
    check("R9 ready after consume", {31'd0, ent_ready}, 32'd1);
    access(12'h015, 2'b11, 0, 1, 32'h4000_0000, 2'b00, "R9 no repeat");

    feed(16'h00FF);
    access(12'h015, 2'b01, 0, 1, 32'h8000_00FF, 2'b00, "R5 super enabled");

    feed(16'h1234);
    ent_bist = 1;
    access(12'h015, 2'b11, 0, 1, 32'h0000_0000, 2'b00, "R12 self-test");
    ent_bist = 0;
    access(12'h015, 2'b11, 0, 1, 32'h8000_1234, 2'b00, "R12 sample survives");

    feed(16'h7777);
    @(negedge clk); ent_fail = 1; ent_bist = 1;
    @(negedge clk); ent_fail = 0;
    access(12'h015, 2'b11, 0, 1, 32'hC000_0000, 2'b00, "R11 dead over self-test");
    ent_bist = 0;
    repeat (3) @(negedge clk);
    access(12'h015, 2'b11, 0, 1, 32'hC000_0000, 2'b00, "R11 dead sticky");
    cfg_useed = 0;
    access(12'h015, 2'b00, 0, 1, 32'h0, 2'b01, "R10 denied while dead");

    repeat (2) @(negedge clk);
    check("R1 all responses seen", q_data.size(), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule